// File: doc/BRIEF.md
# Parallel Address Translation and Cache Probe

This block takes a 32-bit virtual address and, in one lookup cycle, runs a fully associative translation buffer and a direct-mapped data cache side by side. The cache row is picked only from address bits that sit inside the 4 KB page offset, so the row choice never waits on translation. Once the buffer produces a physical page number, that number is compared against the tag stored in the chosen cache row. The block then answers with one of four outcomes: a hit with data, a miss that goes to memory using the translated address, a translation miss, or a protection fault.

Translation entries are loaded through a refill port in rotating slot order. Page-table walking is left to the logic that handles the translation-miss answer. Stores write through: a permitted store updates the cache row and issues a memory write in the same cycle. The control is a three-state machine. `ST_IDLE` accepts a request and moves to `ST_LOOK`. `ST_LOOK` answers at once and returns to `ST_IDLE`, except for a load that misses the cache after translating, which moves to `ST_MEMWAIT`. `ST_MEMWAIT` returns to `ST_IDLE` when read data arrives.

Top module: `tlbc_lookup`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0. Every translation slot and every cache row is empty, so the first access answers kind 2.
- R2: When no valid translation slot matches the page number (bits 31:12), the cycle after acceptance answers `rsp_kind` = 2 (translation miss), and no memory access is issued for that request.
- R3: When translation succeeds and the cache row selected by bits 11:2 is valid with a stored tag equal to the physical page number, a load answers `rsp_kind` = 0 in the cycle after acceptance. The answer carries the cached word and `rsp_paddr` = {physical page, bits 11:0}. Two virtual pages mapped to one physical page therefore share rows.
- R4: A load that translates but misses the cache issues a memory read at `rsp_paddr` in the cycle after acceptance. It answers `rsp_kind` = 1 with the returned word in the cycle `mem_rvalid` is high, and it installs that word so that a repeat load hits.
- R5: A valid cache row whose stored tag differs from the translated page number counts as a miss (kind 1).
- R6: A store to a writable page issues a memory write of `req_wdata` at the physical address in the cycle after acceptance. In the same cycle it answers kind 0 if the row already matched, or kind 1 if not, and it writes the word into the row.
- R7: A store to a page whose write-permit bit is 0 answers `rsp_kind` = 3 (fault). It issues no memory access and leaves the cache row unchanged.
- R8: `rsp_flags` reports the matching slot's {dirty (bit 1), referenced (bit 0)} as held before the access. Any translation hit sets referenced, a permitted store sets dirty, and a refill clears both.
- R9: Refills write slots 0, 1, ... in turn and wrap after the last slot. The page held by the slot that is overwritten then answers kind 2.
- R10: `req_ready` is low from the cycle after a request is accepted until its answer has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address |
| req_wdata | input | 32 | Store data |
| fill_valid | input | 1 | Write a translation slot |
| fill_vpn | input | 20 | Virtual page for the slot |
| fill_ppn | input | 20 | Physical page for the slot |
| fill_writable | input | 1 | Stores permitted on this page |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Physical address for memory |
| mem_wdata | output | 32 | Write data for memory |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read data |
| rsp_valid | output | 1 | Answer present |
| rsp_kind | output | 2 | 0 hit, 1 cache miss, 2 translation miss, 3 fault |
| rsp_flags | output | 2 | {dirty, referenced} before the access |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_data | output | 32 | Load data |

## Verification
The bench builds the block with four translation slots and keeps the default 10-bit cache index and 12-bit page offset. With four slots, the rotating refill wraps after a handful of fills, so slot reuse and the translation miss on an evicted page can be observed. Two pages with different physical frames are given the same page offset, which forces a row conflict and a tag mismatch. A second virtual page aliased to an existing frame shows that the row choice is independent of translation.

// File: rtl/tlbc_pkg.sv
`timescale 1ns/1ps
package tlbc_pkg;
    typedef enum logic [1:0] {
        RK_HIT   = 2'd0,
        RK_MISS  = 2'd1,
        RK_XLATE = 2'd2,
        RK_FAULT = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK,
        ST_MEMWAIT
    } state_e;
endpackage

// File: rtl/tlbc_tlb.sv
`timescale 1ns/1ps
module tlbc_tlb #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_wr,
    output logic [1:0]       hit_flags,
    input  logic             upd_en,
    input  logic             upd_dirty
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     v_q, r_q, d_q, w_q;
    logic [VPN_W-1:0] vpn_q [N];
    logic [PPN_W-1:0] ppn_q [N];
    logic [PW-1:0]    rr_q;
    logic [N-1:0]     match;
    logic [PW-1:0]    hit_idx;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = v_q[g] && (vpn_q[g] == look_vpn);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = PW'(i);
        end
        hit       = |match;
        hit_ppn   = ppn_q[hit_idx];
        hit_wr    = w_q[hit_idx];
        hit_flags = {d_q[hit_idx], r_q[hit_idx]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q  <= '0;
            r_q  <= '0;
            d_q  <= '0;
            w_q  <= '0;
            rr_q <= '0;
        end else begin
            if (upd_en && hit) begin
                r_q[hit_idx] <= 1'b1;
                if (upd_dirty) d_q[hit_idx] <= 1'b1;
            end
            if (fill_en) begin
                v_q[rr_q] <= 1'b1;
                r_q[rr_q] <= 1'b0;
                d_q[rr_q] <= 1'b0;
                w_q[rr_q] <= fill_wr;
                rr_q      <= (rr_q == PW'(N - 1)) ? '0 : rr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            vpn_q[rr_q] <= fill_vpn;
            ppn_q[rr_q] <= fill_ppn;
        end
    end

    // R3
    match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R8
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && hit && !fill_en) |=> r_q[$past(hit_idx)]);
endmodule

// File: rtl/tlbc_dcache.sv
`timescale 1ns/1ps
module tlbc_dcache #(
    parameter int IDX_W = 10,
    parameter int TAG_W = 20,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [DW-1:0]    rd_data,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data
);
    localparam int ROWS = 1 << IDX_W;

    logic [ROWS-1:0]  val_q;
    logic [TAG_W-1:0] tag_q [ROWS];
    logic [DW-1:0]    dat_q [ROWS];

    assign rd_valid = val_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  val_q <= '0;
        else if (we) val_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[wr_idx] <= wr_tag;
            dat_q[wr_idx] <= wr_data;
        end
    end

    // R6
    row_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> val_q[$past(wr_idx)]);
endmodule

// File: rtl/tlbc_lookup.sv
`timescale 1ns/1ps
module tlbc_lookup
    import tlbc_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int PAGE_W = 12,
    parameter int IDX_W  = 10,
    parameter int TLB_N  = 16,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_store,
    input  logic [VA_W-1:0]          req_vaddr,
    input  logic [DW-1:0]            req_wdata,
    input  logic                     fill_valid,
    input  logic [VA_W-PAGE_W-1:0]   fill_vpn,
    input  logic [PA_W-PAGE_W-1:0]   fill_ppn,
    input  logic                     fill_writable,
    output logic                     mem_valid,
    output logic                     mem_write,
    output logic [PA_W-1:0]          mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic                     mem_rvalid,
    input  logic [DW-1:0]            mem_rdata,
    output logic                     rsp_valid,
    output logic [1:0]               rsp_kind,
    output logic [1:0]               rsp_flags,
    output logic [PA_W-1:0]          rsp_paddr,
    output logic [DW-1:0]            rsp_data
);
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PPN_W  = PA_W - PAGE_W;
    localparam int BOFF_W = PAGE_W - IDX_W;

    state_e          state_q, nxt;
    logic [VA_W-1:0] va_q;
    logic            st_q;
    logic [DW-1:0]   wd_q;
    logic [PA_W-1:0] pa_q;
    logic [1:0]      flags_q;

    logic             tlb_hit, tlb_wr;
    logic [PPN_W-1:0] tlb_ppn;
    logic [1:0]       tlb_flags;
    logic             c_valid, c_match, c_we;
    logic [PPN_W-1:0] c_tag, c_wtag;
    logic [DW-1:0]    c_data, c_wdata;
    logic [IDX_W-1:0] idx;
    logic [PA_W-1:0]  paddr;
    logic             in_look;

    assign idx     = va_q[BOFF_W +: IDX_W];
    assign paddr   = {tlb_ppn, va_q[PAGE_W-1:0]};
    assign c_match = c_valid && (c_tag == tlb_ppn);
    assign in_look = (state_q == ST_LOOK);

    tlbc_tlb #(.N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_valid),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .fill_wr   (fill_writable),
        .look_vpn  (va_q[VA_W-1:PAGE_W]),
        .hit       (tlb_hit),
        .hit_ppn   (tlb_ppn),
        .hit_wr    (tlb_wr),
        .hit_flags (tlb_flags),
        .upd_en    (in_look),
        .upd_dirty (st_q && tlb_wr)
    );

    tlbc_dcache #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DW(DW)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (idx),
        .rd_valid (c_valid),
        .rd_tag   (c_tag),
        .rd_data  (c_data),
        .we       (c_we),
        .wr_idx   (idx),
        .wr_tag   (c_wtag),
        .wr_data  (c_wdata)
    );

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) nxt = ST_LOOK;
            ST_LOOK:    nxt = (tlb_hit && !st_q && !c_match) ? ST_MEMWAIT : ST_IDLE;
            ST_MEMWAIT: if (mem_rvalid) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && req_valid) begin
            va_q <= req_vaddr;
            st_q <= req_store;
            wd_q <= req_wdata;
        end
        if (in_look) begin
            pa_q    <= paddr;
            flags_q <= tlb_flags;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        rsp_valid = 1'b0;
        rsp_kind  = RK_HIT;
        rsp_flags = '0;
        rsp_paddr = '0;
        rsp_data  = '0;
        c_we      = 1'b0;
        c_wtag    = tlb_ppn;
        c_wdata   = wd_q;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_LOOK: begin
                if (!tlb_hit) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = RK_XLATE;
                end else if (st_q && !tlb_wr) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = RK_FAULT;
                    rsp_flags = tlb_flags;
                    rsp_paddr = paddr;
                end else if (st_q) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = c_match ? RK_HIT : RK_MISS;
                    rsp_flags = tlb_flags;
                    rsp_paddr = paddr;
                    mem_valid = 1'b1;
                    mem_write = 1'b1;
                    mem_addr  = paddr;
                    mem_wdata = wd_q;
                    c_we      = 1'b1;
                end else if (c_match) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = RK_HIT;
                    rsp_flags = tlb_flags;
                    rsp_paddr = paddr;
                    rsp_data  = c_data;
                end else begin
                    mem_valid = 1'b1;
                    mem_addr  = paddr;
                end
            end
            ST_MEMWAIT: begin
                if (mem_rvalid) begin
                    rsp_valid = 1'b1;
                    rsp_kind  = RK_MISS;
                    rsp_flags = flags_q;
                    rsp_paddr = pa_q;
                    rsp_data  = mem_rdata;
                    c_we      = 1'b1;
                    c_wtag    = pa_q[PA_W-1:PAGE_W];
                    c_wdata   = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    // R2
    xlate_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RK_XLATE) |-> !mem_valid);

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RK_FAULT) |-> (!mem_valid && !c_we));

    // R4
    read_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_write) |=> (state_q == ST_MEMWAIT && !req_ready));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
endmodule

// File: tb/sim_tlbc_lookup.sv
`timescale 1ns/1ps
module sim_tlbc_lookup;
    localparam int NSLOT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [31:0] req_vaddr = '0, req_wdata = '0;
    logic        fill_valid = 1'b0, fill_writable = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        req_ready, mem_valid, mem_write, rsp_valid;
    logic [31:0] mem_addr, mem_wdata, rsp_paddr, rsp_data;
    logic [1:0]  rsp_kind, rsp_flags;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_waddr = '0, last_wdata = '0;
    logic [31:0] mem_model [logic [31:0]];

    typedef struct {
        logic [1:0]  kind;
        logic [1:0]  flags;
        logic [31:0] pa;
        logic [31:0] data;
        bit          cmp_data;
        string       tag;
    } exp_t;
    exp_t exp_q [$];

    always #4 clk = ~clk;

    tlbc_lookup #(.TLB_N(NSLOT)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_writable(fill_writable),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_flags(rsp_flags),
        .rsp_paddr(rsp_paddr), .rsp_data(rsp_data)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return a ^ 32'h5A5A_0000;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (rst_n && mem_valid) begin
            if (mem_write) begin
                wr_cnt++;
                last_waddr = mem_addr;
                last_wdata = mem_wdata;
                mem_model[mem_addr] = mem_wdata;
            end else begin
                logic [31:0] a;
                a = mem_addr;
                rd_cnt++;
                @(posedge clk);
                #1 mem_rvalid = 1'b1;
                mem_rdata = mem_val(a);
                @(posedge clk);
                #1 mem_rvalid = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected response kind", {30'd0, rsp_kind}, 32'hx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(rsp_kind == e.kind, e.tag, "kind", {30'd0, rsp_kind}, {30'd0, e.kind});
                if (e.kind != 2'd2) begin
                    check(rsp_flags == e.flags, e.tag, "flags", {30'd0, rsp_flags}, {30'd0, e.flags});
                    check(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
                end
                if (e.cmp_data)
                    check(rsp_data == e.data, e.tag, "data", rsp_data, e.data);
            end
        end
    end

    task automatic access(input bit st, input logic [31:0] va, input logic [31:0] wd,
                          input logic [1:0] k, input logic [1:0] fl, input logic [31:0] pa,
                          input logic [31:0] dat, input bit cmpd, input string tag);
        exp_t e;
        while (!req_ready) @(negedge clk);
        e.kind = k; e.flags = fl; e.pa = pa; e.data = dat; e.cmp_data = cmpd; e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_store = st; req_vaddr = va; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // R10
        check(req_ready == 1'b0, "R10", "ready while busy", {31'd0, req_ready}, 32'd0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input bit wr);
        while (!req_ready) @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_writable = wr;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        int r0, w0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "ready after reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        check(mem_valid == 1'b0, "R1", "mem_valid after reset", {31'd0, mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 empty translation buffer
        access(0, 32'h0001_2344, 0, 2'd2, 0, 0, 0, 0, "R2");
        check(rd_cnt == 0, "R2", "no memory read", rd_cnt, 0);

        fill(20'h00012, 20'h00345, 1'b1);   // slot 0
        fill(20'h00020, 20'h00777, 1'b0);   // slot 1, read only

        // R4 cold miss then R3 hit, R8 referenced
        access(0, 32'h0001_2344, 0, 2'd1, 2'b00, 32'h0034_5344, mem_val(32'h0034_5344), 1, "R4");
        check(rd_cnt == 1, "R4", "one memory read", rd_cnt, 1);
        access(0, 32'h0001_2344, 0, 2'd0, 2'b01, 32'h0034_5344, mem_val(32'h0034_5344), 1, "R3");

        // R5 same row, other frame
        access(0, 32'h0002_0344, 0, 2'd1, 2'b00, 32'h0077_7344, mem_val(32'h0077_7344), 1, "R5");
        access(0, 32'h0001_2344, 0, 2'd1, 2'b01, 32'h0034_5344, mem_val(32'h0034_5344), 1, "R5");

        // R7 fault on read-only page
        w0 = wr_cnt; r0 = rd_cnt;
        access(1, 32'h0002_0100, 32'hDEAD_BEEF, 2'd3, 2'b01, 32'h0077_7100, 0, 0, "R7");
        check(wr_cnt == w0 && rd_cnt == r0, "R7", "no memory access", wr_cnt, w0);
        access(0, 32'h0002_0100, 0, 2'd1, 2'b01, 32'h0077_7100, 32'h0077_7100 ^ 32'h5A5A_0000, 1, "R7");

        // R6 permitted store, miss then hit
        w0 = wr_cnt;
        access(1, 32'h0001_2200, 32'hCAFE_F00D, 2'd1, 2'b01, 32'h0034_5200, 0, 0, "R6");
        check(wr_cnt == w0 + 1, "R6", "one memory write", wr_cnt, w0 + 1);
        check(last_waddr == 32'h0034_5200, "R6", "write address", last_waddr, 32'h0034_5200);
        check(last_wdata == 32'hCAFE_F00D, "R6", "write data", last_wdata, 32'hCAFE_F00D);
        access(0, 32'h0001_2200, 0, 2'd0, 2'b11, 32'h0034_5200, 32'hCAFE_F00D, 1, "R8");
        access(1, 32'h0001_2200, 32'h1234_5678, 2'd0, 2'b11, 32'h0034_5200, 0, 0, "R6");
        check(last_wdata == 32'h1234_5678, "R6", "write data on hit", last_wdata, 32'h1234_5678);

        // R3 alias page shares the row
        fill(20'h00013, 20'h00345, 1'b1);   // slot 2
        access(0, 32'h0001_3200, 0, 2'd0, 2'b00, 32'h0034_5200, 32'h1234_5678, 1, "R3");

        // R9 rotation wraps to slot 0
        fill(20'h00040, 20'h00900, 1'b1);   // slot 3
        fill(20'h00050, 20'h00A00, 1'b1);   // slot 0 again
        access(0, 32'h0001_2000, 0, 2'd2, 0, 0, 0, 0, "R9");
        access(0, 32'h0002_0000, 0, 2'd1, 2'b01, 32'h0077_7000, mem_val(32'h0077_7000), 1, "R9");
        access(0, 32'h0005_0000, 0, 2'd1, 2'b00, 32'h00A0_0000, mem_val(32'h00A0_0000), 1, "R8");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "pending answers", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule